// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block is the load/store execution path of an out-of-order core. A store leaves the unit as soon as it is accepted: its address, lane-aligned data and byte mask go into a small in-order buffer, and completion is reported with the instruction's tag on the next cycle. Younger instructions can then proceed before the store has reached memory. Buffered stores are written to data memory one at a time, oldest first, and only when the reorder buffer raises its commit signal for the oldest store.

A load reads data memory through the same single port that committed stores use. If a committed store wants the port in the same cycle, the store wins and the load is held off. Memory has a one-cycle synchronous read. While the read is in flight, the buffer is searched for stores to the same word address. Each byte that the youngest such store wrote replaces the memory byte. The merged word is then cut to a byte, halfword or word and sign- or zero-extended, and returned with the load's tag.

The result path is a three-state machine. RSP_NONE means no result this cycle. RSP_STORE is entered on the edge that accepts a store and reports that store's completion. RSP_LOAD is entered on the edge that accepts a load and reports the extended load data. Every cycle the state moves to RSP_LOAD if a load was accepted, to RSP_STORE if a store was accepted, and to RSP_NONE otherwise. At most one operation is accepted per cycle, so these transitions never conflict.

Top module: `stbuf_lsu`

## Requirements
- R1: After reset the buffer is empty, no result is reported (done_valid low), a store is ready to be accepted, and commit_valid is not acknowledged.
- R2: An operation with op_is_store=1 is accepted when op_valid and op_ready are both high. On the next cycle done_valid is high with done_is_load=0, done_tag equal to the accepted tag and done_data zero. No memory write is made at acceptance.
- R3: The size code of a store places the data in byte lanes; lanes the store does not write carry zero.
  - 000 (byte): wdata[7:0] goes to lane addr[1:0], mask bit addr[1:0].
  - 001 (halfword): wdata[15:0] goes to lanes 2*addr[1] and 2*addr[1]+1, mask 2'b11 shifted by 2*addr[1].
  - 010 (word): all four lanes, mask 4'hF.
- R4: While commit_valid is high and the buffer is not empty, commit_ack is high in the same cycle. In that cycle mem_en and mem_we are high, and mem_addr, mem_wdata and mem_wmask carry the oldest buffered store. That entry leaves the buffer at the clock edge, so stores drain in the order they were accepted. With an empty buffer, commit_valid gives no acknowledge and no write.
- R5: In a cycle with commit_ack high, a load is not accepted (op_ready is low for op_is_store=0), while a store is still accepted if the buffer has room.
- R6: A load (op_is_store=0) is accepted when op_valid and op_ready are high. In that cycle mem_en is high, mem_we is low and mem_addr is op_addr[AW-1:2]. On the next cycle done_valid and done_is_load are high and done_tag is the load's tag.
- R7: The load size code selects the result, with byte lane addr[1:0] and halfword at byte offset addr[1:0]:
  - 000: sign-extended byte.
  - 100: zero-extended byte.
  - 001: sign-extended halfword.
  - 101: zero-extended halfword.
  - 010: the whole word.
- R8: For each byte of a loaded word, the value comes from the youngest buffered store with the same word address whose mask covers that byte. Bytes no such store covers come from memory. Stores to other word addresses have no effect on the load.
- R9: When the buffer holds DEPTH stores, op_ready is low for op_is_store=1 and a store presented then is not accepted. Loads remain acceptable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented |
| op_is_store | input | 1 | 1 = store, 0 = load |
| op_size | input | 3 | Access size and extension code |
| op_addr | input | AW | Byte address |
| op_wdata | input | DW | Store data, low-aligned |
| op_tag | input | TAGW | Tag returned with the result |
| op_ready | output | 1 | The presented operation can be accepted |
| done_valid | output | 1 | A result is reported this cycle |
| done_is_load | output | 1 | The result belongs to a load |
| done_tag | output | TAGW | Tag of the reported operation |
| done_data | output | DW | Extended load data, zero for stores |
| commit_valid | input | 1 | Reorder buffer commits the oldest store |
| commit_ack | output | 1 | The oldest store is written this cycle |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW-2 | Word address |
| mem_wdata | output | DW | Write data |
| mem_wmask | output | DW/8 | Byte write mask |
| mem_rdata | input | DW | Read data, one cycle after the read |

## Verification
Loads of every size are first issued against plain memory with no buffered store. This separates the lane selection and extension rules from forwarding, and negative bytes and halfwords tell sign extension apart from zero extension. A store followed by a load to the same word, and then several overlapping stores of different sizes to one word, show whether forwarding merges per byte and lets the youngest store win. A load to a neighbouring word shows that the address match is exact. A full buffer, with commits arriving together with loads and stores, separates the store-first port rule and the full condition from the order in which entries drain, and loads after the drain confirm that memory now holds the merged data.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

    typedef enum logic [2:0] {
        SZ_B  = 3'b000,
        SZ_H  = 3'b001,
        SZ_W  = 3'b010,
        SZ_BU = 3'b100,
        SZ_HU = 3'b101
    } size_e;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_STORE = 2'd1,
        RSP_LOAD  = 2'd2
    } rsp_e;

endpackage

// File: rtl/stbuf_align.sv
module stbuf_align
    import stbuf_pkg::*;
#(
    parameter int DW = 32,
    localparam int NB = DW / 8
) (
    input  logic [2:0]    size,
    input  logic [1:0]    off,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] lane_data,
    output logic [NB-1:0] lane_mask
);

    always_comb begin
        case (size_e'(size))
            SZ_B: begin
                lane_data = DW'(wdata[7:0]) << {off, 3'b000};
                lane_mask = NB'(1) << off;
            end
            SZ_H: begin
                lane_data = DW'(wdata[15:0]) << {off[1], 4'b0000};
                lane_mask = NB'(3) << {off[1], 1'b0};
            end
            default: begin
                lane_data = wdata;
                lane_mask = {NB{1'b1}};
            end
        endcase
    end

endmodule

// File: rtl/stbuf_fifo.sv
module stbuf_fifo #(
    parameter int DEPTH = 4,
    parameter int WAW   = 30,
    parameter int DW    = 32,
    localparam int NB   = DW / 8,
    localparam int PTRW = $clog2(DEPTH),
    localparam int CW   = PTRW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [WAW-1:0] push_waddr,
    input  logic [DW-1:0]  push_data,
    input  logic [NB-1:0]  push_mask,
    input  logic           pop,
    output logic [WAW-1:0] head_waddr,
    output logic [DW-1:0]  head_data,
    output logic [NB-1:0]  head_mask,
    output logic           full,
    output logic           empty,
    input  logic [WAW-1:0] look_waddr,
    output logic [DW-1:0]  fwd_data,
    output logic [NB-1:0]  fwd_mask
);

    logic [WAW-1:0]  ent_waddr [DEPTH];
    logic [DW-1:0]   ent_data  [DEPTH];
    logic [NB-1:0]   ent_mask  [DEPTH];
    logic [PTRW-1:0] head_q, tail_q;
    logic [CW-1:0]   count_q;

    assign full       = (count_q == CW'(DEPTH));
    assign empty      = (count_q == '0);
    assign head_waddr = ent_waddr[head_q];
    assign head_data  = ent_data[head_q];
    assign head_mask  = ent_mask[head_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) begin
                ent_waddr[tail_q] <= push_waddr;
                ent_data[tail_q]  <= push_data;
                ent_mask[tail_q]  <= push_mask;
                tail_q            <= tail_q + 1'b1;
            end
            if (pop) head_q <= head_q + 1'b1;
            if (push && !pop)      count_q <= count_q + 1'b1;
            else if (pop && !push) count_q <= count_q - 1'b1;
        end
    end

    // Walk from oldest to youngest so that later matches overwrite earlier ones.
    always_comb begin
        logic [PTRW-1:0] idx;
        fwd_data = '0;
        fwd_mask = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_q + PTRW'(k);
            if ((CW'(k) < count_q) && (ent_waddr[idx] == look_waddr)) begin
                for (int b = 0; b < NB; b++) begin
                    if (ent_mask[idx][b]) begin
                        fwd_data[8*b +: 8] = ent_data[idx][8*b +: 8];
                        fwd_mask[b]        = 1'b1;
                    end
                end
            end
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty));

    // R4
    count_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/stbuf_extract.sv
module stbuf_extract
    import stbuf_pkg::*;
#(
    parameter int DW = 32,
    localparam int NB = DW / 8
) (
    input  logic [2:0]    size,
    input  logic [1:0]    off,
    input  logic [DW-1:0] fwd_data,
    input  logic [NB-1:0] fwd_mask,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] result
);

    logic [DW-1:0] merged;
    logic [DW-1:0] shifted;

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            merged[8*b +: 8] = fwd_mask[b] ? fwd_data[8*b +: 8] : mem_rdata[8*b +: 8];
        end
    end

    assign shifted = merged >> {off, 3'b000};

    always_comb begin
        case (size_e'(size))
            SZ_B:    result = {{(DW-8){shifted[7]}}, shifted[7:0]};
            SZ_BU:   result = {{(DW-8){1'b0}}, shifted[7:0]};
            SZ_H:    result = {{(DW-16){shifted[15]}}, shifted[15:0]};
            SZ_HU:   result = {{(DW-16){1'b0}}, shifted[15:0]};
            default: result = merged;
        endcase
    end

endmodule

// File: rtl/stbuf_lsu.sv
module stbuf_lsu
    import stbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int TAGW  = 4,
    localparam int WAW  = AW - 2,
    localparam int NB   = DW / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic            op_is_store,
    input  logic [2:0]      op_size,
    input  logic [AW-1:0]   op_addr,
    input  logic [DW-1:0]   op_wdata,
    input  logic [TAGW-1:0] op_tag,
    output logic            op_ready,
    output logic            done_valid,
    output logic            done_is_load,
    output logic [TAGW-1:0] done_tag,
    output logic [DW-1:0]   done_data,
    input  logic            commit_valid,
    output logic            commit_ack,
    output logic            mem_en,
    output logic            mem_we,
    output logic [WAW-1:0]  mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [NB-1:0]   mem_wmask,
    input  logic [DW-1:0]   mem_rdata
);

    logic            sb_full, sb_empty;
    logic [WAW-1:0]  head_waddr;
    logic [DW-1:0]   head_data;
    logic [NB-1:0]   head_mask;
    logic [DW-1:0]   lane_data;
    logic [NB-1:0]   lane_mask;
    logic [DW-1:0]   fwd_data;
    logic [NB-1:0]   fwd_mask;
    logic [DW-1:0]   load_result;
    logic            drain, sto_acc, lod_acc;
    logic [WAW-1:0]  op_waddr;

    rsp_e            rsp_q, rsp_d;
    logic [TAGW-1:0] tag_q;
    logic [2:0]      size_q;
    logic [1:0]      off_q;
    logic [DW-1:0]   fwd_data_q;
    logic [NB-1:0]   fwd_mask_q;

    assign op_waddr   = op_addr[AW-1:2];
    assign drain      = commit_valid && !sb_empty;
    assign commit_ack = drain;
    assign op_ready   = op_is_store ? !sb_full : !drain;
    assign sto_acc    = op_valid && op_ready && op_is_store;
    assign lod_acc    = op_valid && op_ready && !op_is_store;

    assign mem_en    = drain || lod_acc;
    assign mem_we    = drain;
    assign mem_addr  = drain ? head_waddr : op_waddr;
    assign mem_wdata = head_data;
    assign mem_wmask = drain ? head_mask : '0;

    stbuf_align #(.DW(DW)) u_align (
        .size      (op_size),
        .off       (op_addr[1:0]),
        .wdata     (op_wdata),
        .lane_data (lane_data),
        .lane_mask (lane_mask)
    );

    stbuf_fifo #(.DEPTH(DEPTH), .WAW(WAW), .DW(DW)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (sto_acc),
        .push_waddr (op_waddr),
        .push_data  (lane_data),
        .push_mask  (lane_mask),
        .pop        (drain),
        .head_waddr (head_waddr),
        .head_data  (head_data),
        .head_mask  (head_mask),
        .full       (sb_full),
        .empty      (sb_empty),
        .look_waddr (op_waddr),
        .fwd_data   (fwd_data),
        .fwd_mask   (fwd_mask)
    );

    stbuf_extract #(.DW(DW)) u_extract (
        .size      (size_q),
        .off       (off_q),
        .fwd_data  (fwd_data_q),
        .fwd_mask  (fwd_mask_q),
        .mem_rdata (mem_rdata),
        .result    (load_result)
    );

    // Next-state selection of the result machine.
    always_comb begin
        if (lod_acc)      rsp_d = RSP_LOAD;
        else if (sto_acc) rsp_d = RSP_STORE;
        else              rsp_d = RSP_NONE;
    end

    // State register together with the operation context it reports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q      <= RSP_NONE;
            tag_q      <= '0;
            size_q     <= '0;
            off_q      <= '0;
            fwd_data_q <= '0;
            fwd_mask_q <= '0;
        end else begin
            rsp_q <= rsp_d;
            if (sto_acc || lod_acc) begin
                tag_q      <= op_tag;
                size_q     <= op_size;
                off_q      <= op_addr[1:0];
                fwd_data_q <= fwd_data;
                fwd_mask_q <= fwd_mask;
            end
        end
    end

    // Outputs of the result machine.
    always_comb begin
        done_tag = tag_q;
        unique case (rsp_q)
            RSP_STORE: begin
                done_valid   = 1'b1;
                done_is_load = 1'b0;
                done_data    = '0;
            end
            RSP_LOAD: begin
                done_valid   = 1'b1;
                done_is_load = 1'b1;
                done_data    = load_result;
            end
            default: begin
                done_valid   = 1'b0;
                done_is_load = 1'b0;
                done_data    = '0;
            end
        endcase
    end

    // R2
    store_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sto_acc |=> (done_valid && !done_is_load && done_tag == $past(op_tag)));

    // R6
    load_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lod_acc |=> (done_valid && done_is_load && done_tag == $past(op_tag)));

    // R5
    store_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_ack |=> !(done_valid && done_is_load));

endmodule

// File: tb/stbuf_lsu_test.sv
module stbuf_lsu_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid, op_is_store, commit_valid;
    logic [2:0]  op_size;
    logic [31:0] op_addr, op_wdata;
    logic [3:0]  op_tag;
    logic        op_ready, done_valid, done_is_load, commit_ack;
    logic [3:0]  done_tag;
    logic [31:0] done_data;
    logic        mem_en, mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_wmask;
    logic [31:0] mem_rdata;

    always #10 clk = ~clk;

    stbuf_lsu #(.DEPTH(4), .AW(32), .DW(32), .TAGW(4)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_store(op_is_store),
        .op_size(op_size), .op_addr(op_addr), .op_wdata(op_wdata), .op_tag(op_tag),
        .op_ready(op_ready), .done_valid(done_valid), .done_is_load(done_is_load),
        .done_tag(done_tag), .done_data(done_data), .commit_valid(commit_valid),
        .commit_ack(commit_ack), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] initw(int i);
        return 32'h80706050 ^ (32'(i) * 32'h01030507);
    endfunction

    // Environment memory with one-cycle synchronous read.
    logic [31:0] emem [16];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) emem[i] <= initw(i);
            mem_rdata <= '0;
        end else if (mem_en) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_wmask[b]) emem[mem_addr[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= emem[mem_addr[3:0]];
            end
        end
    end

    // Reference model state.
    logic [31:0] rmem [16];
    logic [29:0] qa [$];
    logic [31:0] qd [$];
    logic [3:0]  qm [$];
    logic        e_v, e_l;
    logic [3:0]  e_t;
    logic [31:0] e_d;
    logic [3:0]  tagc;
    int total = 0;
    int bad = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_load(logic [2:0] sz, logic [31:0] a);
        logic [31:0] w, s;
        w = rmem[a[5:2]];
        for (int k = 0; k < qa.size(); k++)
            if (qa[k] == a[31:2])
                for (int b = 0; b < 4; b++)
                    if (qm[k][b]) w[8*b +: 8] = qd[k][8*b +: 8];
        s = w >> (8 * a[1:0]);
        case (sz)
            3'b000:  return {{24{s[7]}}, s[7:0]};
            3'b100:  return {24'h0, s[7:0]};
            3'b001:  return {{16{s[15]}}, s[15:0]};
            3'b101:  return {16'h0, s[15:0]};
            default: return w;
        endcase
    endfunction

    // One clock of stimulus with comparison against the reference model.
    task automatic cyc(input logic v, input logic st, input logic [2:0] sz,
                       input logic [31:0] a, input logic [31:0] wd, input logic cv,
                       input string req);
        logic ex_drain, ex_ready, acc;
        logic [31:0] ld;
        logic [3:0]  lm;
        op_valid = v; op_is_store = st; op_size = sz; op_addr = a;
        op_wdata = wd; op_tag = tagc; commit_valid = cv;
        #2;
        ex_drain = cv && (qa.size() > 0);
        ex_ready = st ? (qa.size() < 4) : !ex_drain;
        acc = v && ex_ready;
        chk(st ? "R9" : "R5", "op_ready", 32'(op_ready), 32'(ex_ready));
        chk("R4", "commit_ack", 32'(commit_ack), 32'(ex_drain));
        chk("R4", "mem_we", 32'(mem_we), 32'(ex_drain));
        chk("R6", "mem_en", 32'(mem_en), 32'(ex_drain || (acc && !st)));
        if (ex_drain) begin
            chk("R4", "mem_addr", 32'(mem_addr), 32'(qa[0]));
            chk("R3", "mem_wdata", mem_wdata, qd[0]);
            chk("R3", "mem_wmask", 32'(mem_wmask), 32'(qm[0]));
        end else if (acc && !st) begin
            chk("R6", "mem_addr", 32'(mem_addr), 32'(a[31:2]));
        end
        e_v = acc; e_l = acc && !st; e_t = tagc; e_d = '0;
        if (acc && !st) e_d = ref_load(sz, a);
        if (ex_drain) begin
            for (int b = 0; b < 4; b++)
                if (qm[0][b]) rmem[qa[0][3:0]][8*b +: 8] = qd[0][8*b +: 8];
            void'(qa.pop_front()); void'(qd.pop_front()); void'(qm.pop_front());
        end
        if (acc && st) begin
            case (sz)
                3'b000:  begin ld = 32'(wd[7:0]) << (8 * a[1:0]);  lm = 4'b0001 << a[1:0]; end
                3'b001:  begin ld = 32'(wd[15:0]) << (16 * a[1]);  lm = 4'b0011 << (2 * a[1]); end
                default: begin ld = wd; lm = 4'hF; end
            endcase
            qa.push_back(a[31:2]); qd.push_back(ld); qm.push_back(lm);
        end
        if (acc) tagc = tagc + 1'b1;
        @(negedge clk);
        #1;
        chk(req, "done_valid", 32'(done_valid), 32'(e_v));
        if (e_v) begin
            chk(req, "done_is_load", 32'(done_is_load), 32'(e_l));
            chk(e_l ? "R6" : "R2", "done_tag", 32'(done_tag), 32'(e_t));
            chk(req, "done_data", done_data, e_d);
        end
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) rmem[i] = initw(i);
        tagc = 4'd1;
        rst_n = 1'b0; op_valid = 1'b0; op_is_store = 1'b1; op_size = 3'b010;
        op_addr = '0; op_wdata = '0; op_tag = '0; commit_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "done_valid in reset", 32'(done_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: empty buffer, store ready, commit not acknowledged
        cyc(1'b0, 1'b1, 3'b010, 32'h0, 32'h0, 1'b1, "R1");

        // R7: plain loads of every size (word0 = 80706050, word1 = 81736557)
        cyc(1'b1, 1'b0, 3'b000, 32'h03, 32'h0, 1'b0, "R7");
        cyc(1'b1, 1'b0, 3'b100, 32'h03, 32'h0, 1'b0, "R7");
        cyc(1'b1, 1'b0, 3'b001, 32'h02, 32'h0, 1'b0, "R7");
        cyc(1'b1, 1'b0, 3'b101, 32'h02, 32'h0, 1'b0, "R7");
        cyc(1'b1, 1'b0, 3'b010, 32'h04, 32'h0, 1'b0, "R7");
        cyc(1'b1, 1'b0, 3'b000, 32'h00, 32'h0, 1'b0, "R7");
        cyc(1'b0, 1'b0, 3'b000, 32'h00, 32'h0, 1'b0, "R6");

        // R2 / R8: byte store then forwarded word load
        cyc(1'b1, 1'b1, 3'b000, 32'h05, 32'h1234_56AB, 1'b0, "R2");
        cyc(1'b1, 1'b0, 3'b010, 32'h04, 32'h0, 1'b0, "R8");
        // R3 / R8: overlapping halfword and byte, youngest byte wins
        cyc(1'b1, 1'b1, 3'b001, 32'h06, 32'hFFFF_1234, 1'b0, "R3");
        cyc(1'b1, 1'b1, 3'b000, 32'h06, 32'h0000_00CD, 1'b0, "R3");
        cyc(1'b1, 1'b0, 3'b010, 32'h04, 32'h0, 1'b0, "R8");
        cyc(1'b1, 1'b0, 3'b001, 32'h06, 32'h0, 1'b0, "R8");
        cyc(1'b1, 1'b0, 3'b100, 32'h08, 32'h0, 1'b0, "R8");

        // R9: fill the buffer, store refused, load still accepted
        cyc(1'b1, 1'b1, 3'b010, 32'h0C, 32'hDEAD_BEEF, 1'b0, "R9");
        cyc(1'b1, 1'b1, 3'b000, 32'h10, 32'h0000_0077, 1'b0, "R9");
        cyc(1'b1, 1'b0, 3'b010, 32'h0C, 32'h0, 1'b0, "R9");

        // R5 / R4: commit together with a load, then with a store
        cyc(1'b1, 1'b0, 3'b010, 32'h04, 32'h0, 1'b1, "R5");
        cyc(1'b1, 1'b1, 3'b010, 32'h14, 32'h0BAD_F00D, 1'b1, "R4");
        cyc(1'b1, 1'b1, 3'b001, 32'h16, 32'h0000_5A5A, 1'b1, "R4");
        cyc(1'b1, 1'b0, 3'b010, 32'h14, 32'h0, 1'b0, "R8");
        for (int i = 0; i < 6; i++)
            cyc(1'b0, 1'b1, 3'b010, 32'h0, 32'h0, 1'b1, "R4");
        // R4: commit with empty buffer does nothing
        cyc(1'b0, 1'b0, 3'b010, 32'h0, 32'h0, 1'b1, "R4");

        // R7 / R4: memory now holds drained data
        cyc(1'b1, 1'b0, 3'b010, 32'h04, 32'h0, 1'b0, "R4");
        cyc(1'b1, 1'b0, 3'b000, 32'h06, 32'h0, 1'b0, "R7");
        cyc(1'b1, 1'b0, 3'b101, 32'h16, 32'h0, 1'b0, "R7");
        cyc(1'b1, 1'b0, 3'b010, 32'h0C, 32'h0, 1'b0, "R4");
        cyc(1'b1, 1'b0, 3'b100, 32'h10, 32'h0, 1'b0, "R4");
        cyc(1'b0, 1'b0, 3'b010, 32'h0, 32'h0, 1'b0, "R6");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule